// File: doc/BRIEF.md
# Mode-Selectable Inverting Bus Transceiver

This block is a bidirectional data slice that sits between a tri-state side (port A) and an open-collector, wired-AND side (port B). Each direction has one storage element. A two-bit mode input sets how that element behaves: combinational pass-through, a level-sensitive latch, or an edge-triggered register. One mode code is split: it registers A-to-B traffic and latches B-to-A traffic. Each direction has its own strobe input. That strobe is the capture edge in register mode and the latch enable in latch mode. Data is inverted on its way through in every mode.

The bidirectional pins are modelled as separate input and output vectors. Port A presents its data together with an output enable. Port B presents a per-bit pull-down enable. A bit whose pull-down is off is released to the pull-up level. Port B is active only when its high-true enable is high and its high-true disable is low. A power-transition hold input also forces port B to release. The strobes are sampled by the block clock `clk`, and a synchronous active-high reset clears both storage elements.

Top module: `xcvr_inv_top`

## Requirements
- R1: `mode_sel` is decoded as follows. 2'b00 makes both directions latches. 2'b01 makes both directions pass-through. 2'b10 makes both directions registers. 2'b11 makes A-to-B a register and B-to-A a latch.
- R2: In pass-through, the output follows the bitwise inverse of the input in the same cycle. The strobe has no effect in this mode.
- R3: In register mode, a direction captures its input at the first `clk` edge at which its strobe is sampled high after being sampled low at the edge before. At all other edges the stored word holds. The output is the inverse of the stored word.
- R4: In latch mode, the output is the inverse of the live input while the strobe is low, and the element loads the input at every edge where the strobe is low. While the strobe is high, the output is the inverse of the word loaded at the last edge where the strobe was low.
- R5: Under code 2'b11, A-to-B acts only on strobe edges (register) while B-to-A is transparent on a low strobe (latch).
- R6: `a_oe` equals `oe_a`. `a_out` carries the B-to-A result whether or not the port is enabled.
- R7: Port B is active only when `b_en`=1, `b_dis`=0 and `pwr_hold`=0. In every other case all bits of `b_pd` are 0, which releases the bus.
- R8: While port B is active, `b_pd[i]`=1 exactly when the driven A-to-B bit i is 0. The driven bit is the inverse of the source, so `b_pd` then equals the stored or passed `a_in` word.
- R9: A storage element keeps loading and holding as usual while its output port is disabled. Its contents appear as soon as the port is enabled again.
- R10: `pwr_hold`=1 releases port B regardless of `b_en` and `b_dis`.
- R11: After `rst`, both stored words are zero. In register mode this gives `a_out` all ones and `b_pd` zero. A strobe that is already high when reset ends does not cause a capture.
- R12: A mode change takes effect in the same cycle, and the output shows the element's current contents without an extra clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the strobes |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Element mode code (see R1) |
| stb_ab | input | 1 | A-to-B capture strobe / latch enable (transparent low) |
| stb_ba | input | 1 | B-to-A capture strobe / latch enable (transparent low) |
| oe_a | input | 1 | Port A output enable, high-true |
| b_en | input | 1 | Port B enable, high-true |
| b_dis | input | 1 | Port B disable, high-true |
| pwr_hold | input | 1 | Power-transition hold, releases port B |
| a_in | input | WIDTH | Data received on port A |
| a_out | output | WIDTH | Data driven on port A |
| a_oe | output | 1 | Port A drive enable |
| b_in | input | WIDTH | Data received on port B (resolved bus) |
| b_pd | output | WIDTH | Per-bit pull-down enable on port B |

## Verification
The bound checker watches several properties on every cycle. It checks that port B never pulls down unless it is enabled and free of the power hold. It checks that the A-to-B register holds across edges without a rising strobe and takes the inverted input after a rising strobe. It also checks that the B-to-A latch is transparent whenever its strobe is low. Some behaviours only the bench scenarios can show. These are the full mode decode, including the split code. They also include what the latch holds after its strobe rises, the loading of an element while its port is disabled, the immediate switch-over on a mode change, and the state right after reset. For these, the bench resolves the B bus as a pulled-up wired-AND.

// File: rtl/xcvr_inv_pkg.sv
package xcvr_inv_pkg;

    typedef enum logic [1:0] {
        EK_PASS  = 2'd0,
        EK_LATCH = 2'd1,
        EK_REG   = 2'd2
    } elem_kind_e;

    typedef struct packed {
        elem_kind_e ab;
        elem_kind_e ba;
    } mode_cfg_t;

    localparam logic [1:0] MODE_LATCH = 2'b00;
    localparam logic [1:0] MODE_PASS  = 2'b01;
    localparam logic [1:0] MODE_REG   = 2'b10;
    localparam logic [1:0] MODE_SPLIT = 2'b11;

    function automatic mode_cfg_t decode_mode(input logic [1:0] sel);
        mode_cfg_t c;
        case (sel)
            MODE_LATCH: begin c.ab = EK_LATCH; c.ba = EK_LATCH; end
            MODE_PASS:  begin c.ab = EK_PASS;  c.ba = EK_PASS;  end
            MODE_REG:   begin c.ab = EK_REG;   c.ba = EK_REG;   end
            default:    begin c.ab = EK_REG;   c.ba = EK_LATCH; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_inv_pkg::*;
#(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  elem_kind_e       kind,
    input  logic             stb,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] held;
    logic             stb_q;
    logic             stb_rise;

    assign stb_rise = stb && !stb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= '0;
            stb_q <= 1'b1;
        end else begin
            stb_q <= stb;
            case (kind)
                EK_REG:   if (stb_rise) held <= d_in;
                EK_LATCH: if (!stb)     held <= d_in;
                default:  held <= held;
            endcase
        end
    end

    always_comb begin
        case (kind)
            EK_PASS:  d_out = ~d_in;
            EK_LATCH: d_out = stb ? ~held : ~d_in;
            default:  d_out = ~held;
        endcase
    end

endmodule

// File: rtl/xcvr_oc_drv.sv
module xcvr_oc_drv #(
    parameter int WIDTH = 9
) (
    input  logic [WIDTH-1:0] drv,
    input  logic             en_hi,
    input  logic             dis_hi,
    input  logic             hold,
    output logic [WIDTH-1:0] pd
);

    logic active;

    assign active = en_hi && !dis_hi && !hold;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign pd[i] = active && !drv[i];
    end

endmodule

// File: rtl/xcvr_inv_top.sv
module xcvr_inv_top
    import xcvr_inv_pkg::*;
#(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic             stb_ab,
    input  logic             stb_ba,
    input  logic             oe_a,
    input  logic             b_en,
    input  logic             b_dis,
    input  logic             pwr_hold,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_pd
);

    mode_cfg_t        cfg;
    logic [WIDTH-1:0] ab_drv;
    logic [WIDTH-1:0] ba_drv;

    assign cfg = decode_mode(mode_sel);

    xcvr_lane #(.WIDTH(WIDTH)) u_lane_ab (
        .clk   (clk),
        .rst   (rst),
        .kind  (cfg.ab),
        .stb   (stb_ab),
        .d_in  (a_in),
        .d_out (ab_drv)
    );

    xcvr_lane #(.WIDTH(WIDTH)) u_lane_ba (
        .clk   (clk),
        .rst   (rst),
        .kind  (cfg.ba),
        .stb   (stb_ba),
        .d_in  (b_in),
        .d_out (ba_drv)
    );

    xcvr_oc_drv #(.WIDTH(WIDTH)) u_oc_drv (
        .drv    (ab_drv),
        .en_hi  (b_en),
        .dis_hi (b_dis),
        .hold   (pwr_hold),
        .pd     (b_pd)
    );

    assign a_out = ba_drv;
    assign a_oe  = oe_a;

endmodule

// File: rtl/xcvr_inv_chk.sv
module xcvr_inv_chk #(
    parameter int WIDTH = 9
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode_sel,
    input logic             stb_ab,
    input logic             stb_ba,
    input logic             b_en,
    input logic             b_dis,
    input logic             pwr_hold,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_pd,
    input logic [WIDTH-1:0] ab_drv
);

    // R7
    b_released_chk: assert property (@(posedge clk) disable iff (rst)
        (b_pd != '0) |-> (b_en && !b_dis && !pwr_hold));

    // R10
    pwr_hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_hold |-> (b_pd == '0));

    // R3
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sel[1] && !stb_ab) |=> (!mode_sel[1] || $stable(ab_drv)));

    // R3
    reg_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && mode_sel[1] && stb_ab && !$past(stb_ab))
        |=> (!mode_sel[1] || ab_drv == ~$past(a_in)));

    // R4
    latch_open_chk: assert property (@(posedge clk) disable iff (rst)
        ((mode_sel == 2'b00 || mode_sel == 2'b11) && !stb_ba) |-> (a_out == ~b_in));

endmodule

bind xcvr_inv_top xcvr_inv_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .stb_ab   (stb_ab),
    .stb_ba   (stb_ba),
    .b_en     (b_en),
    .b_dis    (b_dis),
    .pwr_hold (pwr_hold),
    .a_in     (a_in),
    .a_out    (a_out),
    .b_in     (b_in),
    .b_pd     (b_pd),
    .ab_drv   (ab_drv)
);

// File: tb/xcvr_inv_top_tb.sv
module xcvr_inv_top_tb;

    localparam int W = 9;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   mode_sel = 2'b10;
    logic         stb_ab = 1'b0;
    logic         stb_ba = 1'b0;
    logic         oe_a = 1'b1;
    logic         b_en = 1'b1;
    logic         b_dis = 1'b0;
    logic         pwr_hold = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] a_out;
    logic         a_oe;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] b_pd;
    logic [W-1:0] b_bus;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    xcvr_inv_top #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .stb_ab(stb_ab), .stb_ba(stb_ba),
        .oe_a(oe_a), .b_en(b_en), .b_dis(b_dis), .pwr_hold(pwr_hold),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_pd(b_pd)
    );

    // pulled-up wired-AND bus: a bit reads 0 when any driver pulls it down
    assign b_bus = ~b_pd;

    typedef struct packed {
        logic [1:0]   mode;
        logic         oe_a;
        logic         b_en;
        logic         b_dis;
        logic         hold;
        logic [W-1:0] a_in;
        logic [W-1:0] b_in;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 9'h0A5, 9'h15A},
        '{2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 9'h1FF, 9'h000},
        '{2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 9'h0F0, 9'h123},
        '{2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 9'h155, 9'h0AA},
        '{2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 9'h001, 9'h100},
        '{2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 9'h0C3, 9'h03C},
        '{2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 9'h000, 9'h1FF},
        '{2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 9'h13C, 9'h0C3}
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        #1;
    endtask

    task automatic look();
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R11: reset state in register mode, strobe high at reset release
        stb_ab = 1'b1;
        repeat (3) edge_step();
        rst = 1'b0;
        a_in = 9'h0FF;
        look();
        chk("R11 a_out after reset", a_out, 9'h1FF);
        chk("R11 b_pd after reset", b_pd, 9'h000);
        edge_step();
        look();
        chk("R11 no capture from stale strobe", b_pd, 9'h000);

        // R1 R2 R6 R7 R8 R10: pass-through vector table
        for (int i = 0; i < 8; i++) begin
            edge_step();
            mode_sel = VECS[i].mode; oe_a = VECS[i].oe_a; b_en = VECS[i].b_en;
            b_dis = VECS[i].b_dis; pwr_hold = VECS[i].hold;
            a_in = VECS[i].a_in; b_in = VECS[i].b_in;
            stb_ab = i[0]; stb_ba = i[1];
            look();
            chk("R2 pass a_out", a_out, ~VECS[i].b_in);
            chk("R6 a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, VECS[i].oe_a});
            chk("R7 R8 R10 b_pd", b_pd,
                (VECS[i].b_en && !VECS[i].b_dis && !VECS[i].hold) ? VECS[i].a_in : '0);
        end
        edge_step();
        oe_a = 1'b1; b_en = 1'b1; b_dis = 1'b0; pwr_hold = 1'b0;
        stb_ab = 1'b0; stb_ba = 1'b0;

        // R3: register both directions
        mode_sel = 2'b10;
        edge_step();
        stb_ab = 1'b1; stb_ba = 1'b1; a_in = 9'h0A5; b_in = 9'h033;
        look();
        chk("R3 no capture before edge", b_pd, 9'h000);
        edge_step();
        a_in = 9'h15A; b_in = 9'h1C0;
        look();
        chk("R3 capture ab", b_pd, 9'h0A5);
        chk("R3 capture ba", a_out, ~9'h033);
        edge_step();
        look();
        chk("R3 hold while strobe high", b_pd, 9'h0A5);
        chk("R3 hold ba", a_out, ~9'h033);
        stb_ab = 1'b0;
        edge_step();
        look();
        chk("R3 hold while strobe low", b_pd, 9'h0A5);
        stb_ab = 1'b1;
        edge_step();
        look();
        chk("R3 second capture", b_pd, 9'h15A);

        // R12: mode change is immediate
        edge_step();
        mode_sel = 2'b01; a_in = 9'h007;
        look();
        chk("R12 to pass", b_pd, 9'h007);
        edge_step();
        mode_sel = 2'b10;
        look();
        chk("R12 back to register shows stored", b_pd, 9'h15A);

        // R4: latch both directions
        edge_step();
        mode_sel = 2'b00; stb_ab = 1'b0; stb_ba = 1'b0; a_in = 9'h111; b_in = 9'h0E1;
        look();
        chk("R4 transparent ab", b_pd, 9'h111);
        chk("R4 transparent ba", a_out, ~9'h0E1);
        edge_step();
        stb_ab = 1'b1; stb_ba = 1'b1; a_in = 9'h0EE; b_in = 9'h01E;
        look();
        chk("R4 held ab", b_pd, 9'h111);
        chk("R4 held ba", a_out, ~9'h0E1);
        edge_step();
        look();
        chk("R4 still held", a_out, ~9'h0E1);

        // R5: split code, ab register and ba latch
        edge_step();
        mode_sel = 2'b11; stb_ab = 1'b0; stb_ba = 1'b0; a_in = 9'h0C0; b_in = 9'h10F;
        look();
        chk("R5 ab not transparent", b_pd, 9'h111);
        chk("R5 ba transparent", a_out, ~9'h10F);
        edge_step();
        stb_ab = 1'b1;
        edge_step();
        look();
        chk("R5 ab captured on edge", b_pd, 9'h0C0);
        stb_ba = 1'b1; b_in = 9'h000;
        look();
        chk("R1 R5 ba holds when strobe high", a_out, ~9'h10F);

        // R9: load while ports disabled
        edge_step();
        mode_sel = 2'b10; stb_ab = 1'b0; stb_ba = 1'b0; b_dis = 1'b1; oe_a = 1'b0;
        edge_step();
        stb_ab = 1'b1; stb_ba = 1'b1; a_in = 9'h1A2; b_in = 9'h05D;
        edge_step();
        look();
        chk("R9 b released while disabled", b_pd, 9'h000);
        chk("R9 a_oe low", {{(W-1){1'b0}}, a_oe}, 9'h000);
        b_dis = 1'b0; oe_a = 1'b1;
        look();
        chk("R9 b shows loaded word", b_pd, 9'h1A2);
        chk("R9 bus level", b_bus, ~9'h1A2);
        chk("R9 a shows loaded word", a_out, ~9'h05D);

        // R10: power hold overrides enables
        edge_step();
        pwr_hold = 1'b1;
        look();
        chk("R10 hold releases bus", b_pd, 9'h000);
        edge_step();
        pwr_hold = 1'b0;
        look();
        chk("R10 release after hold", b_pd, 9'h1A2);

        // R11: reset mid-run clears storage
        edge_step();
        rst = 1'b1;
        edge_step();
        rst = 1'b0;
        look();
        chk("R11 reset clears ab", b_pd, 9'h000);
        chk("R11 reset clears ba", a_out, 9'h1FF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule